// File: doc/BRIEF.md
# Dual-Count Byte SPI Master

This block is a byte-wide SPI master that runs one transaction each time it is started. The transmit and receive byte counts are loaded separately. The bus keeps clocking whole bytes until the larger of the two counts has been used up. Each outgoing byte is read through a plain byte-read port, using the byte index as the address. Once the transmit count runs out, a programmable filler byte is shifted out in its place. Incoming bytes are written through a plain byte-write port, and only while the receive count lasts. Later bytes are clocked in and then discarded.

Static inputs set the bit order, clock phase, clock polarity and bit rate. The rate is a one-hot code that selects a divider on the system clock. The block keeps five sticky event flags (started, transmit done, receive done, transaction done, stopped) and a matching interrupt-enable register. The enable register is changed through separate set and clear masks. The interrupt line is high when any flag whose enable is on is set. A stop request ends the transfer cleanly after the byte in flight.

Top module: `spim_dual_count`

## Requirements
- R1: `cfg_mode[0]` selects the bit order: 0 sends and receives the most significant bit first, 1 the least significant bit first. Received bytes are rebuilt in that same order.
- R2: `cfg_mode[1]` is the clock phase and `cfg_mode[2]` the idle level of `sck`. With phase 0, `miso` is sampled on the leading edge and `mosi` changes on the trailing edge. With phase 1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge. When no transfer is running, `sck` equals `cfg_mode[2]`.
- R3: `cfg_rate` with only bit 31 set gives `HALF_MIN` system cycles per `sck` half period. Each lower one-hot code, down to bit 25, doubles that. Any other value is treated as bit 26 (32 × `HALF_MIN` cycles).
- R4: A transaction clocks max(`tx_count`, `rx_count`) bytes. Byte i is read at `tx_rd_addr` = i when i < `tx_count`. Every later byte carries `cfg_fill`.
- R5: Byte i is written to `rx_wr_addr` = i only when i < `rx_count`. A receive count of 0 produces no write.
- R6: After a transaction, `tx_amount` and `rx_amount` hold the number of bytes that actually moved in each direction, that is, min(bytes clocked, count).
- R7: The event flags are sticky: started (bit 19), transmit done (bit 8), transaction done (bit 6), receive done (bit 4) and stopped (bit 1). A flag falls only when the matching bit of `evt_clear` is 1. A count of 0 raises its done flag at start. If both counts are 0, the done flag (bit 6) is also raised at start.
- R8: A stop request ends the transfer at the next byte boundary and returns `sck` to idle. It raises the stopped flag (bit 1) and not the done flag (bit 6).
- R9: A start request is acted on only when `cfg_enable` is 7. Otherwise it has no effect.
- R10: The bits of `inten_set` that are 1 switch the matching enables on. The bits of `inten_clr` that are 1 switch them off. Only bits 1, 4, 6, 8 and 19 exist. `irq` is high exactly when some flag and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 4 | Block enable code (7 = on) |
| cfg_mode | input | 3 | {polarity, phase, LSB-first} |
| cfg_rate | input | 32 | One-hot rate code |
| cfg_fill | input | 8 | Filler byte sent past the transmit count |
| tx_count | input | CNT_W | Transmit byte count |
| rx_count | input | CNT_W | Receive byte count |
| start_req | input | 1 | Start pulse |
| stop_req | input | 1 | Stop pulse |
| tx_rd_en | output | 1 | Transmit byte fetch strobe |
| tx_rd_addr | output | CNT_W | Transmit byte index |
| tx_rd_data | input | 8 | Transmit byte, valid in the same cycle as the strobe |
| rx_wr_en | output | 1 | Receive byte write strobe |
| rx_wr_addr | output | CNT_W | Receive byte index |
| rx_wr_data | output | 8 | Received byte |
| tx_amount | output | CNT_W | Bytes sent from the buffer |
| rx_amount | output | CNT_W | Bytes stored to the buffer |
| evt_clear | input | 32 | Per-flag clear mask |
| inten_set | input | 32 | Interrupt-enable set mask |
| inten_clr | input | 32 | Interrupt-enable clear mask |
| evt_flags | output | 32 | Sticky event flags |
| inten | output | 32 | Interrupt enables |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Transaction in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A corrupted byte index or count latch shows up within one byte time, as a wrong fetch address or a missing or extra receive write. A corrupted shift register or bit selector corrupts a byte as soon as the next byte boundary is reached. A wrong edge counter leaves `sck` off its idle level when `busy` falls. It also skews the data one half period against the serial slave model. Flag and enable faults appear at `evt_flags`, `inten` and `irq` two cycles after the end of the transfer.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int EVB_STOPPED = 1;
   localparam int EVB_ENDRX   = 4;
   localparam int EVB_END     = 6;
   localparam int EVB_ENDTX   = 8;
   localparam int EVB_STARTED = 19;
   localparam logic [31:0] EV_MASK = (32'd1 << EVB_STOPPED) | (32'd1 << EVB_ENDRX) |
                                     (32'd1 << EVB_END) | (32'd1 << EVB_ENDTX) |
                                     (32'd1 << EVB_STARTED);
   localparam logic [3:0] ENABLE_ON = 4'd7;
   localparam int BYTE_W = 8;

   // position inside a byte of the k-th bit on the wire
   function automatic logic [2:0] bit_slot(input logic [2:0] k, input logic lsb_first);
      return lsb_first ? k : 3'd7 - k;
   endfunction
endpackage

// File: rtl/spim_rate_div.sv
module spim_rate_div #(
   parameter int HALF_MIN = 1,
   parameter int CW       = $clog2(HALF_MIN * 64 + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic [31:0] rate_code,
   output logic        tick
);
   localparam int NCODE   = 7;
   localparam int LOW_BIT = 25;
   localparam int DEF_SEL = 1;

   if (HALF_MIN < 1) begin : g_bad_half
      $error("spim_rate_div: HALF_MIN must be at least 1");
   end

   logic [CW-1:0] half_tbl [NCODE];
   logic [CW-1:0] half_sel;
   logic [CW-1:0] cnt_q;

   for (genvar g = 0; g < NCODE; g++) begin : g_tbl
      assign half_tbl[g] = CW'(HALF_MIN << (NCODE - 1 - g));
   end

   always_comb begin
      half_sel = half_tbl[DEF_SEL];
      for (int k = 0; k < NCODE; k++) begin
         if (rate_code == (32'd1 << (LOW_BIT + k))) half_sel = half_tbl[k];
      end
   end

   assign tick = run && (cnt_q >= half_sel - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run || tick)   cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R3: the divider never runs past the slowest half period
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(HALF_MIN * 64));
endmodule

// File: rtl/spim_shift_engine.sv
module spim_shift_engine
   import spim_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop_req,
   input  logic              tick,
   input  logic [2:0]        mode,
   input  logic [BYTE_W-1:0] fill,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [BYTE_W-1:0] tx_rd_data,
   input  logic              miso,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   output logic              tx_rd_en,
   output logic [CNT_W-1:0]  tx_rd_addr,
   output logic              rx_wr_en,
   output logic [CNT_W-1:0]  rx_wr_addr,
   output logic [BYTE_W-1:0] rx_wr_data,
   output logic [CNT_W-1:0]  tx_amount,
   output logic [CNT_W-1:0]  rx_amount,
   output logic              ev_started,
   output logic              ev_endtx,
   output logic              ev_endrx,
   output logic              ev_end,
   output logic              ev_stopped
);
   localparam logic [3:0] LAST_EDGE = 4'hF;

   logic              busy_q, order_q, cpha_q, cpol_q, stop_q, sck_q, mosi_q;
   logic [BYTE_W-1:0] fill_q, tx_byte_q, rx_byte_q, rx_next, ld_byte;
   logic [CNT_W-1:0]  txc_q, rxc_q, total_q, idx_q, total_in, ld_idx, ld_txc, idx_inc;
   logic [3:0]        edge_q;
   logic [2:0]        k;
   logic              start_go, lead, fin, stopping, last, load, sample;
   logic              ld_order, ld_cpha;

   assign total_in = (tx_count > rx_count) ? tx_count : rx_count;
   assign start_go = start && !busy_q;
   assign k        = edge_q[3:1];
   assign lead     = !edge_q[0];
   assign idx_inc  = idx_q + 1'b1;
   assign fin      = busy_q && tick && (edge_q == LAST_EDGE);
   assign stopping = stop_q || stop_req;
   assign last     = fin && ((idx_inc == total_q) || stopping);
   assign load     = (start_go && (total_in != '0)) || (fin && !last);
   assign ld_idx   = start_go ? '0 : idx_inc;
   assign ld_txc   = start_go ? tx_count : txc_q;
   assign ld_order = start_go ? mode[0] : order_q;
   assign ld_cpha  = start_go ? mode[1] : cpha_q;
   assign tx_rd_en   = load && (ld_idx < ld_txc);
   assign tx_rd_addr = ld_idx;
   assign ld_byte  = tx_rd_en ? tx_rd_data : (start_go ? fill : fill_q);
   // phase 0 samples on leading edges, phase 1 on trailing edges
   assign sample   = busy_q && tick && (lead != cpha_q);

   always_comb begin
      rx_next = rx_byte_q;
      if (sample) rx_next[bit_slot(k, order_q)] = miso;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;  order_q <= 1'b0;  cpha_q <= 1'b0;  cpol_q <= 1'b0;
         stop_q <= 1'b0;  sck_q <= 1'b0;    mosi_q <= 1'b0;
         fill_q <= '0;    tx_byte_q <= '0;  rx_byte_q <= '0;
         txc_q <= '0;     rxc_q <= '0;      total_q <= '0;   idx_q <= '0;
         edge_q <= '0;    tx_amount <= '0;  rx_amount <= '0;
         rx_wr_en <= 1'b0; rx_wr_addr <= '0; rx_wr_data <= '0;
         ev_started <= 1'b0; ev_endtx <= 1'b0; ev_endrx <= 1'b0;
         ev_end <= 1'b0;     ev_stopped <= 1'b0;
      end else begin
         ev_started <= 1'b0; ev_endtx <= 1'b0; ev_endrx <= 1'b0;
         ev_end <= 1'b0;     ev_stopped <= 1'b0; rx_wr_en <= 1'b0;
         if (start_go) begin
            order_q <= mode[0];  cpha_q <= mode[1];  cpol_q <= mode[2];
            sck_q   <= mode[2];  fill_q <= fill;
            txc_q   <= tx_count; rxc_q <= rx_count; total_q <= total_in;
            idx_q   <= '0;       edge_q <= '0;
            tx_amount <= '0;     rx_amount <= '0;
            stop_q  <= stop_req;
            ev_started <= 1'b1;
            ev_endtx   <= (tx_count == '0);
            ev_endrx   <= (rx_count == '0);
            if (total_in == '0) begin
               ev_end     <= 1'b1;
               ev_stopped <= stop_req;
            end else begin
               busy_q <= 1'b1;
            end
         end else if (busy_q) begin
            if (stop_req) stop_q <= 1'b1;
            if (tick) begin
               sck_q     <= ~sck_q;
               edge_q    <= edge_q + 1'b1;
               rx_byte_q <= rx_next;
               if (lead && cpha_q)
                  mosi_q <= tx_byte_q[bit_slot(k, order_q)];
               if (!lead && !cpha_q && (k != 3'd7))
                  mosi_q <= tx_byte_q[bit_slot(k + 3'd1, order_q)];
               if (fin) begin
                  idx_q <= idx_inc;
                  if (idx_q < txc_q) tx_amount <= tx_amount + 1'b1;
                  if (idx_q < rxc_q) begin
                     rx_amount  <= rx_amount + 1'b1;
                     rx_wr_en   <= 1'b1;
                     rx_wr_addr <= idx_q;
                     rx_wr_data <= rx_next;
                  end
                  ev_endtx <= (idx_inc == txc_q);
                  ev_endrx <= (idx_inc == rxc_q);
                  if (last) begin
                     busy_q     <= 1'b0;
                     stop_q     <= 1'b0;
                     ev_end     <= (idx_inc == total_q);
                     ev_stopped <= stopping;
                  end
               end
            end
         end else if (stop_req) begin
            ev_stopped <= 1'b1;
         end
         if (load) begin
            tx_byte_q <= ld_byte;
            if (!ld_cpha) mosi_q <= ld_byte[bit_slot(3'd0, ld_order)];
         end
      end
   end

   assign busy = busy_q;
   assign sck  = busy_q ? sck_q : mode[2];
   assign mosi = mosi_q;

   // R2: a finished or stopped transfer has toggled the clock back to idle
   assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (sck_q == cpol_q));
   // R8: the transfer ends only on a byte boundary
   assert_byte_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (edge_q == 4'h0));
   // R4: the byte index stays below the number of bytes to clock
   assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q < total_q));
   // R6: the amounts never exceed their counts
   assert_amount_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ((tx_amount <= txc_q) && (rx_amount <= rxc_q)));
   // R5: each receive write is counted in the amount
   assert_rx_amount_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wr_en |-> (rx_amount == rx_wr_addr + 1'b1));
endmodule

// File: rtl/spim_event_regs.sv
module spim_event_regs
   import spim_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] ev_pulse,
   input  logic [31:0] evt_clear,
   input  logic [31:0] inten_set,
   input  logic [31:0] inten_clr,
   output logic [31:0] flags,
   output logic [31:0] inten,
   output logic        irq
);
   for (genvar i = 0; i < 32; i++) begin : g_bit
      if (EV_MASK[i]) begin : g_live
         logic flag_q, en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
               en_q   <= 1'b0;
            end else begin
               if (ev_pulse[i])       flag_q <= 1'b1;
               else if (evt_clear[i]) flag_q <= 1'b0;
               if (inten_set[i])      en_q <= 1'b1;
               else if (inten_clr[i]) en_q <= 1'b0;
            end
         end
         assign flags[i] = flag_q;
         assign inten[i] = en_q;
      end else begin : g_tie
         assign flags[i] = 1'b0;
         assign inten[i] = 1'b0;
      end
   end

   assign irq = |(flags & inten);

   // R7: a flag stays set until its clear bit is written
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(flags & ~evt_clear)) == $past(flags & ~evt_clear)));
   // R10: a set mask switches on every existing enable it names
   assert_inten_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (inten_set != '0) |=> ((inten & $past(inten_set & EV_MASK)) == $past(inten_set & EV_MASK)));
endmodule

// File: rtl/spim_dual_count.sv
module spim_dual_count
   import spim_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int HALF_MIN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cfg_enable,
   input  logic [2:0]        cfg_mode,
   input  logic [31:0]       cfg_rate,
   input  logic [7:0]        cfg_fill,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic              start_req,
   input  logic              stop_req,
   output logic              tx_rd_en,
   output logic [CNT_W-1:0]  tx_rd_addr,
   input  logic [7:0]        tx_rd_data,
   output logic              rx_wr_en,
   output logic [CNT_W-1:0]  rx_wr_addr,
   output logic [7:0]        rx_wr_data,
   output logic [CNT_W-1:0]  tx_amount,
   output logic [CNT_W-1:0]  rx_amount,
   input  logic [31:0]       evt_clear,
   input  logic [31:0]       inten_set,
   input  logic [31:0]       inten_clr,
   output logic [31:0]       evt_flags,
   output logic [31:0]       inten,
   output logic              irq,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("spim_dual_count: CNT_W must be 1 to 32");
   end

   logic        tick, start_ok;
   logic        ev_started, ev_endtx, ev_endrx, ev_end, ev_stopped;
   logic [31:0] ev_vec;

   assign start_ok = start_req && (cfg_enable == ENABLE_ON);

   spim_rate_div #(.HALF_MIN(HALF_MIN)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .rate_code(cfg_rate), .tick(tick));

   spim_shift_engine #(.CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start_ok), .stop_req(stop_req), .tick(tick),
      .mode(cfg_mode), .fill(cfg_fill), .tx_count(tx_count), .rx_count(rx_count),
      .tx_rd_data(tx_rd_data), .miso(miso), .busy(busy), .sck(sck), .mosi(mosi),
      .tx_rd_en(tx_rd_en), .tx_rd_addr(tx_rd_addr), .rx_wr_en(rx_wr_en),
      .rx_wr_addr(rx_wr_addr), .rx_wr_data(rx_wr_data), .tx_amount(tx_amount),
      .rx_amount(rx_amount), .ev_started(ev_started), .ev_endtx(ev_endtx),
      .ev_endrx(ev_endrx), .ev_end(ev_end), .ev_stopped(ev_stopped));

   always_comb begin
      ev_vec              = '0;
      ev_vec[EVB_STARTED] = ev_started;
      ev_vec[EVB_ENDTX]   = ev_endtx;
      ev_vec[EVB_ENDRX]   = ev_endrx;
      ev_vec[EVB_END]     = ev_end;
      ev_vec[EVB_STOPPED] = ev_stopped;
   end

   spim_event_regs u_evt (
      .clk(clk), .rst_n(rst_n), .ev_pulse(ev_vec), .evt_clear(evt_clear),
      .inten_set(inten_set), .inten_clr(inten_clr), .flags(evt_flags),
      .inten(inten), .irq(irq));

   // R9: a start request while not enabled leaves the block idle
   assert_start_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && (cfg_enable != ENABLE_ON) && !busy) |=> !busy);
endmodule

// File: tb/spim_dual_count_tb.sv
module spim_dual_count_tb;
   localparam int CNT_W = 16;
   localparam logic [31:0] EVS = (32'd1 << 19) | (32'd1 << 8) | (32'd1 << 6) | (32'd1 << 4);

   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0]  cfg_enable = '0;
   logic        b_order = 0, b_cpha = 0, b_cpol = 0;
   logic [31:0] cfg_rate = 32'h8000_0000;
   logic [7:0]  cfg_fill = 8'hE7;
   logic [CNT_W-1:0] tx_count = '0, rx_count = '0;
   logic start_req = 0, stop_req = 0;
   logic [31:0] evt_clear = '0, inten_set = '0, inten_clr = '0;
   logic tx_rd_en, rx_wr_en, irq, busy, sck, mosi, miso;
   logic [CNT_W-1:0] tx_rd_addr, rx_wr_addr, tx_amount, rx_amount;
   logic [7:0] tx_rd_data, rx_wr_data;
   logic [31:0] evt_flags, inten;

   logic [7:0] tx_mem [16];
   logic [7:0] slave_mem [16];
   logic [7:0]  exp_mosi [$];
   logic [23:0] exp_rx [$];
   int tests = 0, fails = 0, cyc = 0;
   int s_e = 0, s_bi = 0;
   logic s_prev = 0, s_rst = 0;
   logic [7:0] s_cap = '0;

   always #4 clk = ~clk;

   spim_dual_count #(.CNT_W(CNT_W), .HALF_MIN(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode({b_cpol, b_cpha, b_order}),
      .cfg_rate(cfg_rate), .cfg_fill(cfg_fill), .tx_count(tx_count), .rx_count(rx_count),
      .start_req(start_req), .stop_req(stop_req), .tx_rd_en(tx_rd_en), .tx_rd_addr(tx_rd_addr),
      .tx_rd_data(tx_rd_data), .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr),
      .rx_wr_data(rx_wr_data), .tx_amount(tx_amount), .rx_amount(rx_amount),
      .evt_clear(evt_clear), .inten_set(inten_set), .inten_clr(inten_clr),
      .evt_flags(evt_flags), .inten(inten), .irq(irq), .busy(busy), .sck(sck),
      .mosi(mosi), .miso(miso));

   assign tx_rd_data = tx_mem[tx_rd_addr[3:0]];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // slave model: drives miso from slave_mem, rebuilds mosi bytes (R1, R2)
   always_comb begin
      int kk;
      kk = b_cpha ? ((s_e == 0) ? 0 : (s_e - 1) / 2) : s_e / 2;
      if (kk > 7) kk = 7;
      miso = slave_mem[s_bi[3:0]][b_order ? kk : 7 - kk];
   end

   always @(negedge clk) begin
      if (s_rst) begin
         s_e = 0; s_bi = 0; s_prev = sck; s_cap = '0;
      end else if (sck !== s_prev) begin
         logic lead;
         int kk;
         logic [7:0] want;
         s_prev = sck;
         lead = (sck != b_cpol);
         kk = s_e / 2;
         if (lead != b_cpha) s_cap[b_order ? kk : 7 - kk] = mosi;
         s_e++;
         if (s_e == 16) begin
            if (exp_mosi.size() == 0) chk(0, "R4 unexpected mosi byte", {24'd0, s_cap}, 0);
            else begin
               want = exp_mosi.pop_front();
               chk(s_cap == want, "R1/R4 mosi byte", {24'd0, s_cap}, {24'd0, want});
            end
            s_e = 0; s_bi++;
         end
      end
   end

   // monitor for receive-buffer writes (R5)
   always @(negedge clk) begin
      if (rst_n && rx_wr_en) begin
         if (exp_rx.size() == 0) chk(0, "R5 unexpected rx write", {8'd0, rx_wr_addr, rx_wr_data}, 0);
         else begin
            logic [23:0] w;
            w = exp_rx.pop_front();
            chk({rx_wr_addr, rx_wr_data} == w, "R1/R5 rx write", {8'd0, rx_wr_addr, rx_wr_data}, {8'd0, w});
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic clear_events();
      evt_clear = '1; @(negedge clk); evt_clear = '0;
   endtask

   task automatic run_xfer(input logic [2:0] mode, input logic [31:0] rate, input int txn,
                           input int rxn, input int nb, input int stop_dly, input string tag);
      {b_cpol, b_cpha, b_order} = mode;
      cfg_rate = rate;
      tx_count = CNT_W'(txn); rx_count = CNT_W'(rxn);
      @(negedge clk); s_rst = 1; @(negedge clk); s_rst = 0;
      for (int i = 0; i < nb; i++) begin
         exp_mosi.push_back(i < txn ? tx_mem[i] : cfg_fill);
         if (i < rxn) exp_rx.push_back({i[15:0], slave_mem[i]});
      end
      clear_events();
      start_req = 1; @(negedge clk); start_req = 0;
      if (stop_dly > 0) begin
         repeat (stop_dly) @(negedge clk);
         stop_req = 1; @(negedge clk); stop_req = 0;
      end
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(tx_amount == CNT_W'(txn < nb ? txn : nb), {tag, " R6 tx_amount"}, tx_amount, txn < nb ? txn : nb);
      chk(rx_amount == CNT_W'(rxn < nb ? rxn : nb), {tag, " R6 rx_amount"}, rx_amount, rxn < nb ? rxn : nb);
      chk(exp_mosi.size() == 0, {tag, " R4 missing mosi bytes"}, exp_mosi.size(), 0);
      chk(exp_rx.size() == 0, {tag, " R5 missing rx writes"}, exp_rx.size(), 0);
      chk(sck == b_cpol, {tag, " R2 sck idle"}, sck, b_cpol);
      exp_mosi.delete(); exp_rx.delete();
   endtask

   task automatic measure_half(input logic [31:0] rate, input int want, input string tag);
      int n;
      logic p;
      {b_cpol, b_cpha, b_order} = 3'b000;
      cfg_rate = rate; tx_count = 1; rx_count = 0;
      @(negedge clk); s_rst = 1; @(negedge clk); s_rst = 0;
      exp_mosi.push_back(tx_mem[0]);
      start_req = 1; @(negedge clk); start_req = 0;
      p = sck;
      while (sck == p) @(negedge clk);
      p = sck; n = 0;
      while (sck == p) begin @(negedge clk); n++; end
      chk(n == want, {tag, " R3 half period"}, n, want);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      exp_mosi.delete(); exp_rx.delete();
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         tx_mem[i]    = 8'(8'h3C + i * 37);
         slave_mem[i] = 8'(8'hA5 ^ (i * 29));
      end
      s_rst = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); s_rst = 0;
      // reset state
      chk(evt_flags == 0, "R7 reset flags", evt_flags, 0);
      chk(irq == 0 && inten == 0, "R10 reset irq/inten", {inten[30:0], irq}, 0);
      chk(busy == 0, "R9 reset busy", busy, 0);
      chk(tx_amount == 0 && rx_amount == 0, "R6 reset amounts", tx_amount, 0);

      // R9: start while disabled
      cfg_enable = 4'd5; tx_count = 3; rx_count = 3;
      start_req = 1; @(negedge clk); start_req = 0;
      repeat (40) @(negedge clk);
      chk(busy == 0, "R9 disabled start busy", busy, 0);
      chk(evt_flags == 0, "R9 disabled start flags", evt_flags, 0);

      cfg_enable = 4'd7;
      // R1/R2 mode 0, MSB first, equal counts
      run_xfer(3'b000, 32'h8000_0000, 3, 3, 3, 0, "A");
      chk(evt_flags == EVS, "R7 flags after A", evt_flags, EVS);
      // R1/R2 mode 3, LSB first, receive longer: filler bytes R4
      run_xfer(3'b111, 32'h8000_0000, 2, 4, 4, 0, "B");
      chk(evt_flags == EVS, "R7 flags after B", evt_flags, EVS);
      // R5: receive count 0, phase 1 polarity 0
      run_xfer(3'b010, 32'h4000_0000, 4, 0, 4, 0, "C");
      // R4: transmit count 0, polarity 1 phase 0, LSB
      run_xfer(3'b101, 32'h8000_0000, 0, 2, 2, 0, "D");
      // R7: sticky flag survives until clear
      repeat (5) @(negedge clk);
      chk(evt_flags == EVS, "R7 flags hold", evt_flags, EVS);
      evt_clear = 32'd1 << 19; @(negedge clk); evt_clear = '0; @(negedge clk);
      chk(evt_flags == (EVS & ~(32'd1 << 19)), "R7 single clear", evt_flags, EVS & ~(32'd1 << 19));

      // R3 rates
      measure_half(32'h1000_0000, 8, "rate1M");
      measure_half(32'h0000_0000, 32, "rate_default");
      measure_half(32'h8000_0000, 1, "rate8M");

      // R8 stop after the first byte
      run_xfer(3'b000, 32'h8000_0000, 6, 6, 1, 3, "STOP");
      chk(evt_flags == ((32'd1 << 19) | (32'd1 << 1)), "R8 stop flags", evt_flags, (32'd1 << 19) | (32'd1 << 1));

      // zero counts: done at once
      run_xfer(3'b000, 32'h8000_0000, 0, 0, 0, 0, "ZERO");
      chk(evt_flags == EVS, "R7 zero-count flags", evt_flags, EVS);

      // R10 interrupt enables
      clear_events();
      inten_set = 32'hFFFF_FFFF & ((32'd1 << 6) | (32'd1 << 19) | (32'd1 << 3));
      @(negedge clk); inten_set = '0; @(negedge clk);
      chk(inten == ((32'd1 << 6) | (32'd1 << 19)), "R10 inten set", inten, (32'd1 << 6) | (32'd1 << 19));
      chk(irq == 0, "R10 irq with no flags", irq, 0);
      run_xfer(3'b000, 32'h8000_0000, 1, 1, 1, 0, "IRQ");
      chk(irq == 1, "R10 irq raised", irq, 1);
      evt_clear = (32'd1 << 6) | (32'd1 << 19); @(negedge clk); evt_clear = '0; @(negedge clk);
      chk(irq == 0, "R10 irq after clear", irq, 0);
      inten_clr = 32'd1 << 6; @(negedge clk); inten_clr = '0; @(negedge clk);
      chk(inten == (32'd1 << 19), "R10 inten clear", inten, 32'd1 << 19);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule